// File: doc/BRIEF.md
# Self-Timed Manchester Packet Receiver

This block takes one serial line, already synchronised to the system clock, and recovers fixed-length Manchester-coded packets from it without being told the bit rate. Every packet opens with two reference clock transitions. The receiver counts system clocks between them and uses that count as the bit period for the rest of the packet. Between clock transitions the line may hold a mid-bit transition. Any transition that arrives too early to be a clock edge is ignored. The value of each bit is the line level just after its clock transition, so a rising clock edge is a 1 and a falling one is a 0.

After the 47th data clock edge, the receiver splits the frame into a 31-bit payload and a 16-bit checksum, then recomputes the checksum over the payload. A match produces a one-cycle valid strobe and updates the payload output. A mismatch produces a one-cycle error strobe and leaves the payload output alone. A lateness watchdog drops the packet and returns the receiver to idle when an expected clock edge is missing. The measured period is kept on an output so it can be observed.

Top module: `manchesterRx`

## Requirements
- R1: After reset, `busy`, `validOut` and `crcErr` are 0, `dataOut` is 0, `periodOut` is 0, and the line history is taken as 0.
- R2: A transition seen while idle raises `busy` in the next cycle. `busy` stays high until the packet completes or is abandoned.
- R3: The gap in system clocks between the first and second transitions of a packet is accepted as the period P when MIN_PERIOD ≤ gap ≤ MAX_PERIOD. P then appears on `periodOut` one cycle after the second transition is sampled.
- R4: A reference gap shorter than MIN_PERIOD, or no second transition within MAX_PERIOD clocks, abandons the packet. `busy` drops, no strobe is produced and `periodOut` keeps its old value.
- R5: During data reception, a transition fewer than P − ⌊P/4⌋ clocks after the last clock edge is ignored (mid-bit). The first transition from that point up to P + ⌊P/4⌋ clocks is the next clock edge, and its bit value is the new line level.
- R6: If no clock edge is seen within P + ⌊P/4⌋ clocks of the previous one, reception is abandoned with no strobe, and `busy` drops.
- R7: A frame is 47 bits in arrival order: 31 payload bits MSB first, then 16 checksum bits MSB first. The checksum is CRC-16 with polynomial 0x1021, initial value 0xFFFF and no final inversion, taken over the payload bits MSB first.
- R8: When the checksum matches, `validOut` pulses for exactly one cycle, two cycles after the 47th clock edge is sampled. `dataOut` takes the payload in that same cycle, and `busy` falls in that same cycle.
- R9: When the checksum does not match, `crcErr` pulses for one cycle at the same point, and `dataOut` keeps the last good payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLine | input | 1 | Synchronised Manchester serial line |
| busy | output | 1 | High while a packet is being received |
| validOut | output | 1 | One-cycle strobe: good packet |
| crcErr | output | 1 | One-cycle strobe: checksum mismatch |
| dataOut | output | PAY_W | Last good payload |
| periodOut | output | CNT_W | Last accepted reference period, in clocks |

## Verification
The line is sampled at the rising edge. `busy` follows one cycle after a start transition is sampled. `periodOut` is updated one cycle after the second reference transition. Both strobes arrive two cycles after the final clock edge is sampled, one register for the frame and one for the result. The bench model advances at each falling edge, using the line value that the next rising edge will see. It compares its predicted outputs at the falling edge after that, so every result is checked in exactly the cycle it is due. Boundary timings (P = MIN_PERIOD, a clock edge exactly P + ⌊P/4⌋ late, and one clock later than that) are also checked against the intended outcome of each packet.

// File: rtl/mrxPkg.sv
package mrxPkg;
  localparam int CRC_W = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_REF, ST_DATA, ST_DONE} rxState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic cntRestart;
    logic cntRun;
    logic perLoad;
    logic shiftBit;
    logic frameDone;
  } rxCtrl_t;

  // datapath -> control status
  typedef struct packed {
    logic edgeSeen;
    logic refInRange;
    logic refTimeout;
    logic clkWindow;
    logic bitTimeout;
    logic lastBit;
  } rxStat_t;
endpackage

// File: rtl/mrxControl.sv
module mrxControl
  import mrxPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  rxStat_t stat,
  output rxCtrl_t ctrl,
  output logic    busy
);
  rxState_e state, stateNx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNx;
  end

  always_comb begin
    stateNx = state;
    ctrl    = '0;
    unique case (state)
      ST_IDLE: begin
        if (stat.edgeSeen) begin
          ctrl.cntRestart = 1'b1;
          stateNx = ST_REF;
        end
      end
      ST_REF: begin
        ctrl.cntRun = 1'b1;
        if (stat.edgeSeen) begin
          if (stat.refInRange) begin
            ctrl.perLoad    = 1'b1;
            ctrl.cntRestart = 1'b1;
            stateNx = ST_DATA;
          end else begin
            stateNx = ST_IDLE;
          end
        end else if (stat.refTimeout) begin
          stateNx = ST_IDLE;
        end
      end
      ST_DATA: begin
        ctrl.cntRun = 1'b1;
        if (stat.edgeSeen && stat.clkWindow) begin
          ctrl.shiftBit   = 1'b1;
          ctrl.cntRestart = 1'b1;
          if (stat.lastBit) stateNx = ST_DONE;
        end else if (stat.bitTimeout) begin
          stateNx = ST_IDLE;
        end
      end
      ST_DONE: begin
        ctrl.frameDone = 1'b1;
        stateNx = ST_IDLE;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/mrxDatapath.sv
module mrxDatapath
  import mrxPkg::*;
#(
  parameter int          PAY_W      = 31,
  parameter int          MIN_PERIOD = 200,
  parameter int          MAX_PERIOD = 1000,
  parameter int          CNT_W      = 11,
  parameter logic [15:0] CRC_POLY   = 16'h1021,
  parameter logic [15:0] CRC_INIT   = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  rxCtrl_t          ctrl,
  output rxStat_t          stat,
  output logic             validOut,
  output logic             crcErr,
  output logic [PAY_W-1:0] dataOut,
  output logic [CNT_W-1:0] periodOut
);
  localparam int FRAME_W = PAY_W + CRC_W;
  localparam int IDX_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(MIN_PERIOD);
  localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(MAX_PERIOD);
  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(FRAME_W - 1);

  logic               lineQ;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   perQ;
  logic [CNT_W-1:0]   thrEarly, thrLate;
  logic [IDX_W-1:0]   bitIdx;
  logic [FRAME_W-1:0] shReg;
  logic [CRC_W-1:0]   crcCalc;
  logic               crcOk;

  function automatic logic [CRC_W-1:0] crcOf(input logic [PAY_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = CRC_INIT;
    for (int i = PAY_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  // line history and interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ <= 1'b0;
      cnt   <= '0;
    end else begin
      lineQ <= rxLine;
      if (ctrl.cntRestart)  cnt <= CNT_W'(1);
      else if (ctrl.cntRun) cnt <= cnt + CNT_W'(1);
    end
  end

  // period capture, bit index and frame shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perQ   <= '0;
      bitIdx <= '0;
      shReg  <= '0;
    end else begin
      if (ctrl.perLoad) begin
        perQ   <= cnt;
        bitIdx <= '0;
      end else if (ctrl.shiftBit) begin
        bitIdx <= bitIdx + IDX_W'(1);
      end
      if (ctrl.shiftBit) shReg <= {shReg[FRAME_W-2:0], rxLine};
    end
  end

  assign thrEarly = perQ - (perQ >> 2);
  assign thrLate  = perQ + (perQ >> 2);
  assign crcCalc  = crcOf(shReg[FRAME_W-1:CRC_W]);
  assign crcOk    = (crcCalc == shReg[CRC_W-1:0]);

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validOut <= 1'b0;
      crcErr   <= 1'b0;
      dataOut  <= '0;
    end else begin
      validOut <= ctrl.frameDone & crcOk;
      crcErr   <= ctrl.frameDone & ~crcOk;
      if (ctrl.frameDone && crcOk) dataOut <= shReg[FRAME_W-1:CRC_W];
    end
  end

  always_comb begin
    stat.edgeSeen   = rxLine ^ lineQ;
    stat.refInRange = (cnt >= MIN_C) && (cnt <= MAX_C);
    stat.refTimeout = (cnt > MAX_C);
    stat.clkWindow  = (cnt >= thrEarly) && (cnt <= thrLate);
    stat.bitTimeout = (cnt > thrLate);
    stat.lastBit    = (bitIdx == LAST_I);
  end

  assign periodOut = perQ;
endmodule

// File: rtl/manchesterRx.sv
module manchesterRx
  import mrxPkg::*;
#(
  parameter int          PAY_W      = 31,
  parameter int          MIN_PERIOD = 200,
  parameter int          MAX_PERIOD = 1000,
  parameter logic [15:0] CRC_POLY   = 16'h1021,
  parameter logic [15:0] CRC_INIT   = 16'hFFFF,
  localparam int         CNT_W      = $clog2(2 * MAX_PERIOD)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  output logic             busy,
  output logic             validOut,
  output logic             crcErr,
  output logic [PAY_W-1:0] dataOut,
  output logic [CNT_W-1:0] periodOut
);
  rxCtrl_t ctrl;
  rxStat_t stat;

  mrxControl uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .stat (stat),
    .ctrl (ctrl),
    .busy (busy)
  );

  mrxDatapath #(
    .PAY_W      (PAY_W),
    .MIN_PERIOD (MIN_PERIOD),
    .MAX_PERIOD (MAX_PERIOD),
    .CNT_W      (CNT_W),
    .CRC_POLY   (CRC_POLY),
    .CRC_INIT   (CRC_INIT)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .rxLine    (rxLine),
    .ctrl      (ctrl),
    .stat      (stat),
    .validOut  (validOut),
    .crcErr    (crcErr),
    .dataOut   (dataOut),
    .periodOut (periodOut)
  );
endmodule

// File: rtl/mrxChecker.sv
module mrxChecker #(
  parameter int PAY_W      = 31,
  parameter int MIN_PERIOD = 200,
  parameter int MAX_PERIOD = 1000,
  parameter int CNT_W      = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             validOut,
  input logic             crcErr,
  input logic [PAY_W-1:0] dataOut,
  input logic [CNT_W-1:0] periodOut
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    validOut |=> !validOut); // R8
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    crcErr |=> !crcErr); // R9
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(validOut && crcErr)); // R9
  AST_STROBE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (validOut || crcErr) |-> (!busy && $past(busy))); // R8
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> $stable(dataOut)); // R9
  AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (periodOut != '0) |-> (periodOut >= CNT_W'(MIN_PERIOD) && periodOut <= CNT_W'(MAX_PERIOD))); // R3
  AST_PERIOD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(periodOut) |-> (busy && $past(busy))); // R4
endmodule

bind manchesterRx mrxChecker #(
  .PAY_W      (PAY_W),
  .MIN_PERIOD (MIN_PERIOD),
  .MAX_PERIOD (MAX_PERIOD),
  .CNT_W      (CNT_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .validOut  (validOut),
  .crcErr    (crcErr),
  .dataOut   (dataOut),
  .periodOut (periodOut)
);

// File: tb/tb_manchesterRx.sv
`timescale 1ns/1ps
module tb_manchesterRx;
  localparam int PAY = 31;
  localparam int MINP = 200;
  localparam int MAXP = 1000;
  localparam int CW = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b0;
  logic busy, validOut, crcErr;
  logic [PAY-1:0] dataOut;
  logic [CW-1:0] periodOut;

  always #2 clk = ~clk; // 250 MHz

  manchesterRx dut (.clk(clk), .rstN(rstN), .rxLine(rxLine), .busy(busy),
    .validOut(validOut), .crcErr(crcErr), .dataOut(dataOut), .periodOut(periodOut));

  int tests = 0, fails = 0;
  int validCnt = 0, errCnt = 0;
  bit run = 0;

  // behavioural reference model
  int cyc = 0, lastCyc = 0, mSt = 0, mBits = 0, mPer = 0;
  logic mPrev = 0;
  logic [46:0] mFrame = '0;
  logic mBusy = 0, mValid = 0, mErr = 0;
  logic [PAY-1:0] mData = '0;

  function automatic logic [15:0] crc16(input logic [PAY-1:0] d);
    logic [15:0] c = 16'hFFFF;
    for (int i = PAY - 1; i >= 0; i--) begin
      if (c[15] ^ d[i]) c = (c << 1) ^ 16'h1021;
      else c = c << 1;
    end
    return c;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      int age, thr, lim;
      logic edg;
      check("R2", "busy", busy, mBusy);
      check("R8", "validOut", validOut, mValid);
      check("R9", "crcErr", crcErr, mErr);
      check("R9", "dataOut", dataOut, mData);
      check("R3", "periodOut", periodOut, mPer);
      validCnt += int'(validOut);
      errCnt   += int'(crcErr);
      edg = (rxLine != mPrev);
      mPrev = rxLine;
      age = cyc - lastCyc;
      mValid = 0; mErr = 0;
      case (mSt)
        0: if (edg) begin lastCyc = cyc; mSt = 1; end
        1: if (edg) begin
             if (age >= MINP && age <= MAXP) begin
               mPer = age; lastCyc = cyc; mBits = 0; mSt = 2;
             end else mSt = 0;
           end else if (age > MAXP) mSt = 0;
        2: begin
             thr = mPer - mPer / 4; lim = mPer + mPer / 4;
             if (edg && age >= thr && age <= lim) begin
               mFrame = {mFrame[45:0], rxLine};
               mBits++; lastCyc = cyc;
               if (mBits == 47) mSt = 3;
             end else if (age > lim) mSt = 0;
           end
        default: begin
             if (crc16(mFrame[46:16]) == mFrame[15:0]) begin
               mValid = 1; mData = mFrame[46:16];
             end else mErr = 1;
             mSt = 0;
           end
      endcase
      mBusy = (mSt != 0);
      cyc++;
    end
  end

  task automatic waitC(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // dropAt: bit whose clock edge is omitted (-1 none); lateAt/lateBy: delayed clock edge
  task automatic sendPkt(input logic [PAY-1:0] pay, input int per, input bit badCrc,
                         input int dropAt, input int lateAt, input int lateBy);
    logic [46:0] fr;
    logic [15:0] c;
    c = crc16(pay) ^ (badCrc ? 16'h0001 : 16'h0000);
    fr = {pay, c};
    rxLine = ~rxLine; waitC(per);
    rxLine = ~rxLine;
    for (int i = 46; i >= 0; i--) begin
      int idx, extra;
      idx = 46 - i;
      extra = (idx == lateAt) ? lateBy : 0;
      if (rxLine == fr[i]) begin
        waitC(per / 2); rxLine = ~rxLine; waitC(per - per / 2 + extra);
      end else waitC(per + extra);
      if (idx == dropAt) return;
      rxLine = ~rxLine;
    end
  endtask

  task automatic outcome(input string req, input int v0, input int e0, input int ev, input int ee,
                         input logic [PAY-1:0] expData, input int expPer);
    waitC(2600);
    check(req, "valid strobes", validCnt - v0, ev);
    check(req, "error strobes", errCnt - e0, ee);
    check(req, "payload", dataOut, expData);
    check(req, "period", periodOut, expPer);
    check(req, "idle busy", busy, 0);
  endtask

  initial begin
    fork
      begin
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none
    waitC(5);
    check("R1", "reset busy", busy, 0);
    check("R1", "reset valid", validOut, 0);
    check("R1", "reset err", crcErr, 0);
    check("R1", "reset data", dataOut, 0);
    check("R1", "reset period", periodOut, 0);
    rstN = 1'b1; run = 1;
    waitC(10);
    begin
      int v, e;
      // R7 R8: minimum period, mixed payload
      v = validCnt; e = errCnt;
      sendPkt(31'h2A5C_3E91, MINP, 0, -1, -1, 0);
      outcome("R8", v, e, 1, 0, 31'h2A5C_3E91, MINP);
      // R5: alternating bits (no mid-bit) and all ones (every bit mid-bit)
      v = validCnt; e = errCnt;
      sendPkt(31'h5555_5555, 260, 0, -1, -1, 0);
      outcome("R5", v, e, 1, 0, 31'h5555_5555, 260);
      v = validCnt; e = errCnt;
      sendPkt(31'h7FFF_FFFF, 230, 0, -1, -1, 0);
      outcome("R7", v, e, 1, 0, 31'h7FFF_FFFF, 230);
      // R9: bad checksum keeps old payload
      v = validCnt; e = errCnt;
      sendPkt(31'h0123_4567, 220, 1, -1, -1, 0);
      outcome("R9", v, e, 0, 1, 31'h7FFF_FFFF, 220);
      // R4: reference too short and too long
      v = validCnt; e = errCnt;
      sendPkt(31'h1111_1111, 150, 0, 0, -1, 0);
      outcome("R4", v, e, 0, 0, 31'h7FFF_FFFF, 220);
      v = validCnt; e = errCnt;
      rxLine = ~rxLine; waitC(MAXP + 100); rxLine = ~rxLine;
      outcome("R4", v, e, 0, 0, 31'h7FFF_FFFF, 220);
      // R6: dropped clock edge
      v = validCnt; e = errCnt;
      sendPkt(31'h3333_0F0F, 240, 0, 20, -1, 0);
      outcome("R6", v, e, 0, 0, 31'h7FFF_FFFF, 240);
      // R5: clock edge exactly at P + P/4 still accepted
      v = validCnt; e = errCnt;
      sendPkt(31'h1C0F_FE01, MINP, 0, -1, 10, MINP / 4);
      outcome("R5", v, e, 1, 0, 31'h1C0F_FE01, MINP);
      // R6: one clock later aborts
      v = validCnt; e = errCnt;
      sendPkt(31'h0F0F_0F0F, MINP, 0, 12, 12, MINP / 4 + 1);
      outcome("R6", v, e, 0, 0, 31'h1C0F_FE01, MINP);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule